// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits between a CPU write path and a byte-wide non-volatile array and runs every program or erase cycle itself. Software picks an operation by writing a mode code into a control register, then writes data into the memory window exactly as if it were storing to RAM. The sequencer gathers those bytes into a load buffer. When the byte count the operation needs has been reached, it launches the erase phase, the program phase, or both, with no separate "go" command.

Five operations exist:
- single byte
- four-byte word
- standard block (erase then program)
- fast block (program only, into an already blank block)
- block erase

Completion and refused-write events are kept as two flags. Both flags clear when the next cycle launches, and both clear when the status register is read. A small model of the array, with fixed erase and program durations, is part of the block so that contents and timing can be observed. Unlock state and per-block protection come in as plain inputs.

Top module: `flash_op_seq`

## Requirements
- R1: The control byte selects the operation. Low-seven-bit value 0x01 is standard block, 0x10 is fast block, 0x20 is block erase and 0x40 is word. Any other value, 0x00 included, selects byte mode. Bit 7 is the fixed-time bit. Once a cycle launches, the operation field returns to byte mode and the fixed-time bit is kept.
- R2: Word and block loads must begin at the first address of the word or block and continue at consecutive addresses. A first write at any other address, or a later write to an address out of sequence, is ignored. `loading` is high while a load is incomplete, and the cycle begins on the clock edge that accepts the final byte.
- R3: While fewer bytes than required have been loaded, no cycle starts, `busy` stays low and the array is unchanged, for as long as the load is left unfinished.
- R4: In erase mode, four 0x00 bytes written to consecutive addresses from any word-aligned address inside a block clear the whole block to 0x00.
- R5: `busy` stays high for exactly T_ERASE+T_PROG cycles for a standard block, a word, or a byte whose word is not blank. It stays high for T_PROG cycles for a fast block or a byte into a blank word, and for T_ERASE cycles for a block erase.
- R6: A standard block or word cycle leaves the target equal to the loaded bytes. A fast block cycle ORs the loaded bytes into the existing contents.
- R7: A byte write updates one byte of its 4-byte word and keeps the other three bytes. The word is erased first only when it holds a non-zero byte, unless the fixed-time bit forces the erase. Writing 0x00 leaves that byte erased.
- R8: A window write made while `unlock` is low, or into a block whose `prot_mask` bit is set, sets the write-protect flag (status bit 1), starts no cycle and leaves the array unchanged.
- R9: The done flag (status bit 0) sets on the edge where `busy` falls, and `irq` follows it.
- R10: Both flags read as zero from the first cycle of any newly launched operation.
- R11: A status read returns the current flags and clears both on the next edge. A flag being set on that same edge takes priority over the clear.
- R12: A write that arrives after a word or block cycle has run is handled as an independent byte write.
- R13: After reset the array holds all zeros, both flags are clear, `busy` and `loading` are low, and `busy` and `loading` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unlock | input | 1 | Write enable coming from the key logic |
| prot_mask | input | NUM_BLKS | Per-block write protection |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control byte |
| mem_wr | input | 1 | Memory window write strobe |
| mem_addr | input | log2(BLK_BYTES*NUM_BLKS) | Window byte address; also the read address |
| mem_wdata | input | 8 | Window write data |
| mem_rdata | output | 8 | Array byte at `mem_addr` |
| stat_rd | input | 1 | Status read strobe (clears the flags) |
| stat_rdata | output | 8 | Bit 0 done, bit 1 write-protect attempt |
| busy | output | 1 | An erase or program cycle is running; holds CPU accesses |
| loading | output | 1 | A word or block load is incomplete |
| irq | output | 1 | Completion interrupt, level |

## Verification
Every block of a small array goes through a standard block program with a pattern that differs per address. A fast block then ORs a second pattern into one of those blocks, which separates overwrite behaviour from OR behaviour. Byte writes into blank words, into non-blank words and with the fixed-time bit set are told apart only by the `busy` duration, so that duration is measured on every cycle. Stalled loads, loads interrupted by an out-of-sequence address and loads started at a misaligned address show that only a complete, ordered load launches a cycle. Locked and protected writes are followed by a protected-flag clear on the next launch.

// File: rtl/fos_pkg.sv
package fos_pkg;

    localparam int WORD_BYTES = 4;

    // Control byte codes (low seven bits)
    localparam logic [6:0] CODE_BLK_STD   = 7'h01;
    localparam logic [6:0] CODE_BLK_FAST  = 7'h10;
    localparam logic [6:0] CODE_BLK_ERASE = 7'h20;
    localparam logic [6:0] CODE_WORD      = 7'h40;
    localparam int         CTL_FIXED_BIT  = 7;

    // Status bit positions
    localparam int STAT_DONE_BIT  = 0;
    localparam int STAT_WPROT_BIT = 1;

    typedef enum logic [2:0] {
        OP_BYTE,
        OP_WORD,
        OP_BLK_STD,
        OP_BLK_FAST,
        OP_BLK_ERASE
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ERASE,
        ST_PROG
    } st_e;

    typedef struct packed {
        op_e  op;
        logic fixed;
    } ctl_t;

    typedef struct packed {
        logic erase;
        logic prog;
        logic whole_blk;
    } plan_t;

    function automatic ctl_t decode_ctl(input logic [7:0] v);
        ctl_t c;
        c.fixed = v[CTL_FIXED_BIT];
        case (v[6:0])
            CODE_BLK_STD:   c.op = OP_BLK_STD;
            CODE_BLK_FAST:  c.op = OP_BLK_FAST;
            CODE_BLK_ERASE: c.op = OP_BLK_ERASE;
            CODE_WORD:      c.op = OP_WORD;
            default:        c.op = OP_BYTE;
        endcase
        return c;
    endfunction

    // Phases and region of a loaded (non-byte) operation
    function automatic plan_t plan_for(input op_e op);
        plan_t p;
        p.erase     = (op == OP_WORD) || (op == OP_BLK_STD) || (op == OP_BLK_ERASE);
        p.prog      = (op != OP_BLK_ERASE);
        p.whole_blk = (op == OP_BLK_STD) || (op == OP_BLK_FAST) || (op == OP_BLK_ERASE);
        return p;
    endfunction

endpackage

// File: rtl/fos_tmr.sv
module fos_tmr #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/fos_ldbuf.sv
module fos_ldbuf
    import fos_pkg::*;
#(
    parameter int BLK_BYTES = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                we,
    input  logic [$clog2(BLK_BYTES)-1:0]        idx,
    input  logic [7:0]                          wdata,
    input  logic                                seed_we,
    input  logic [WORD_BYTES-1:0][7:0]          seed,
    output logic [BLK_BYTES-1:0][7:0]           ld_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ld_q <= '0;
        end else if (seed_we) begin
            for (int i = 0; i < WORD_BYTES; i++) ld_q[i] <= seed[i];
        end else if (we) begin
            ld_q[idx] <= wdata;
        end
    end
endmodule

// File: rtl/fos_array.sv
module fos_array
    import fos_pkg::*;
#(
    parameter int BLK_BYTES = 8,
    parameter int NUM_BLKS  = 4
) (
    input  logic                                        clk,
    input  logic                                        rst,
    input  logic                                        erase_go,
    input  logic                                        prog_go,
    input  logic [$clog2(BLK_BYTES*NUM_BLKS)-1:0]       base,
    input  logic                                        whole_blk,
    input  logic [BLK_BYTES-1:0][7:0]                   ld,
    output logic [BLK_BYTES*NUM_BLKS-1:0][7:0]          cells
);
    localparam int MEM_BYTES = BLK_BYTES * NUM_BLKS;
    localparam int AW        = $clog2(MEM_BYTES);
    localparam int IW        = $clog2(BLK_BYTES);

    logic [MEM_BYTES-1:0] hit;
    logic [AW-1:0]        off [MEM_BYTES];

    for (genvar i = 0; i < MEM_BYTES; i++) begin : g_cell
        assign off[i] = AW'(i) - base;
        assign hit[i] = whole_blk ? (off[i] < AW'(BLK_BYTES))
                                  : (off[i] < AW'(WORD_BYTES));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cells <= '0;
        end else begin
            for (int i = 0; i < MEM_BYTES; i++) begin
                if (hit[i]) begin
                    if (erase_go)     cells[i] <= '0;
                    else if (prog_go) cells[i] <= cells[i] | ld[off[i][IW-1:0]];
                end
            end
        end
    end
endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
    import fos_pkg::*;
#(
    parameter int BLK_BYTES = 8,
    parameter int NUM_BLKS  = 4,
    parameter int T_ERASE   = 6,
    parameter int T_PROG    = 4
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   unlock,
    input  logic [NUM_BLKS-1:0]                    prot_mask,
    input  logic                                   ctl_wr,
    input  logic [7:0]                             ctl_wdata,
    input  logic                                   mem_wr,
    input  logic [$clog2(BLK_BYTES*NUM_BLKS)-1:0]  mem_addr,
    input  logic [7:0]                             mem_wdata,
    output logic [7:0]                             mem_rdata,
    input  logic                                   stat_rd,
    output logic [7:0]                             stat_rdata,
    output logic                                   busy,
    output logic                                   loading,
    output logic                                   irq
);
    localparam int MEM_BYTES = BLK_BYTES * NUM_BLKS;
    localparam int AW        = $clog2(MEM_BYTES);
    localparam int IW        = $clog2(BLK_BYTES);
    localparam int TMAX      = (T_ERASE > T_PROG) ? T_ERASE : T_PROG;
    localparam int TW        = $clog2(TMAX + 1);

    // State
    ctl_t          mode_q;
    st_e           st_q;
    op_e           op_q;
    logic [AW-1:0] base_q;
    logic [IW:0]   cnt_q;
    logic          do_prog_q, whole_q;
    logic          done_q, wprot_q;

    logic [MEM_BYTES-1:0][7:0] cells;
    logic [BLK_BYTES-1:0][7:0] ld_q;

    // Address decode
    logic                        allowed, blank, first_ok, next_ok, last;
    logic [AW-1:0]               word_base, exp_addr;
    logic [WORD_BYTES-1:0][7:0]  cur_word, merged;
    logic [IW:0]                 need;
    plan_t                       plan;

    always_comb begin
        word_base = {mem_addr[AW-1:2], 2'b00};
        for (int k = 0; k < WORD_BYTES; k++)
            cur_word[k] = cells[{mem_addr[AW-1:2], k[1:0]}];
        merged                = cur_word;
        merged[mem_addr[1:0]] = mem_wdata;
        blank                 = (cur_word == '0);
        allowed               = unlock && !prot_mask[mem_addr[AW-1:IW]];
        case (mode_q.op)
            OP_WORD:      first_ok = (mem_addr[1:0] == 2'b00);
            OP_BLK_ERASE: first_ok = (mem_addr[1:0] == 2'b00) && (mem_wdata == 8'h00);
            OP_BLK_STD,
            OP_BLK_FAST:  first_ok = (mem_addr[IW-1:0] == '0);
            default:      first_ok = 1'b0;
        endcase
        need     = ((op_q == OP_WORD) || (op_q == OP_BLK_ERASE)) ? (IW+1)'(WORD_BYTES)
                                                                  : (IW+1)'(BLK_BYTES);
        exp_addr = base_q + AW'(cnt_q);
        next_ok  = (mem_addr == exp_addr) && ((op_q != OP_BLK_ERASE) || (mem_wdata == 8'h00));
        last     = ((cnt_q + (IW+1)'(1)) == need);
        plan     = plan_for(op_q);
    end

    // Write classification
    logic idle_st, load_st, win_wr;
    logic first_go, byte_start, load_begin, next_go, blk_start, start, rej;

    assign idle_st    = (st_q == ST_IDLE);
    assign load_st    = (st_q == ST_LOAD);
    assign win_wr     = mem_wr && !ctl_wr && (idle_st || load_st);
    assign rej        = win_wr && !allowed;
    assign first_go   = win_wr && allowed && idle_st;
    assign byte_start = first_go && (mode_q.op == OP_BYTE);
    assign load_begin = first_go && (mode_q.op != OP_BYTE) && first_ok;
    assign next_go    = win_wr && allowed && load_st && next_ok;
    assign blk_start  = next_go && last;
    assign start      = byte_start || blk_start;

    // Launch parameters
    logic          s_erase, s_prog, s_whole;
    logic [AW-1:0] s_base;

    always_comb begin
        if (byte_start) begin
            s_erase = mode_q.fixed || !blank;
            s_prog  = 1'b1;
            s_whole = 1'b0;
            s_base  = word_base;
        end else begin
            s_erase = plan.erase;
            s_prog  = plan.prog;
            s_whole = plan.whole_blk;
            s_base  = plan.whole_blk ? {base_q[AW-1:IW], {IW{1'b0}}} : base_q;
        end
    end

    // Phase timer
    logic          t_zero, tmr_load, erase_go, prog_go, done_set;
    logic [TW-1:0] tmr_val;

    assign erase_go = (st_q == ST_ERASE) && t_zero;
    assign prog_go  = (st_q == ST_PROG) && t_zero;
    assign done_set = prog_go || (erase_go && !do_prog_q);
    assign tmr_load = start || (erase_go && do_prog_q);
    assign tmr_val  = (start && s_erase) ? TW'(T_ERASE - 1) : TW'(T_PROG - 1);

    fos_tmr #(.W(TW)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .val  (tmr_val),
        .zero (t_zero)
    );

    fos_ldbuf #(.BLK_BYTES(BLK_BYTES)) u_ld (
        .clk     (clk),
        .rst     (rst),
        .we      (load_begin || next_go),
        .idx     (load_begin ? {IW{1'b0}} : cnt_q[IW-1:0]),
        .wdata   (mem_wdata),
        .seed_we (byte_start),
        .seed    (merged),
        .ld_q    (ld_q)
    );

    fos_array #(.BLK_BYTES(BLK_BYTES), .NUM_BLKS(NUM_BLKS)) u_arr (
        .clk       (clk),
        .rst       (rst),
        .erase_go  (erase_go),
        .prog_go   (prog_go),
        .base      (base_q),
        .whole_blk (whole_q),
        .ld        (ld_q),
        .cells     (cells)
    );

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '{op: OP_BYTE, fixed: 1'b0};
            st_q      <= ST_IDLE;
            op_q      <= OP_BYTE;
            base_q    <= '0;
            cnt_q     <= '0;
            do_prog_q <= 1'b0;
            whole_q   <= 1'b0;
        end else begin
            if (ctl_wr) begin
                mode_q <= decode_ctl(ctl_wdata);
                if (load_st) st_q <= ST_IDLE;
            end
            case (st_q)
                ST_IDLE, ST_LOAD: begin
                    if (start) begin
                        st_q      <= s_erase ? ST_ERASE : ST_PROG;
                        base_q    <= s_base;
                        do_prog_q <= s_prog;
                        whole_q   <= s_whole;
                        mode_q.op <= OP_BYTE;
                    end else if (load_begin) begin
                        st_q   <= ST_LOAD;
                        base_q <= mem_addr;
                        op_q   <= mode_q.op;
                        cnt_q  <= (IW+1)'(1);
                    end else if (next_go) begin
                        cnt_q <= cnt_q + (IW+1)'(1);
                    end
                end
                ST_ERASE: if (t_zero) st_q <= do_prog_q ? ST_PROG : ST_IDLE;
                ST_PROG:  if (t_zero) st_q <= ST_IDLE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    // Status flags
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            wprot_q <= 1'b0;
        end else if (start) begin
            done_q  <= 1'b0;
            wprot_q <= 1'b0;
        end else begin
            if (done_set)     done_q <= 1'b1;
            else if (stat_rd) done_q <= 1'b0;
            if (rej)          wprot_q <= 1'b1;
            else if (stat_rd) wprot_q <= 1'b0;
        end
    end

    always_comb begin
        stat_rdata                 = '0;
        stat_rdata[STAT_DONE_BIT]  = done_q;
        stat_rdata[STAT_WPROT_BIT] = wprot_q;
    end

    assign mem_rdata = cells[mem_addr];
    assign busy      = (st_q == ST_ERASE) || (st_q == ST_PROG);
    assign loading   = load_st;
    assign irq       = done_q;
endmodule

// File: rtl/fos_chk.sv
module fos_chk (
    input logic       clk,
    input logic       rst,
    input logic       unlock,
    input logic       ctl_wr,
    input logic       mem_wr,
    input logic       stat_rd,
    input logic [7:0] stat_rdata,
    input logic       busy,
    input logic       loading,
    input logic       irq
);
    assert_excl_R13: assert property (@(posedge clk) disable iff (rst)
        !(busy && loading));

    assert_done_at_end_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (stat_rdata[0] && irq));

    assert_done_only_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_rdata[0]) |-> $past(busy));

    assert_start_clears_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (stat_rdata[1:0] == 2'b00));

    assert_read_clears_R11: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !busy && !mem_wr) |=> (stat_rdata[1:0] == 2'b00));

    assert_locked_refused_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !unlock && !busy && !ctl_wr) |=> (stat_rdata[1] && !busy));
endmodule

bind flash_op_seq fos_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .unlock     (unlock),
    .ctl_wr     (ctl_wr),
    .mem_wr     (mem_wr),
    .stat_rd    (stat_rd),
    .stat_rdata (stat_rdata),
    .busy       (busy),
    .loading    (loading),
    .irq        (irq)
);

// File: tb/flash_op_seq_tb.sv
module flash_op_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BLK  = 8;
    localparam int NB   = 4;
    localparam int MEMB = BLK * NB;
    localparam int AW   = $clog2(MEMB);
    localparam int TE   = 6;
    localparam int TP   = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          unlock = 1'b1;
    logic [NB-1:0] prot_mask = '0;
    logic          ctl_wr = 1'b0;
    logic [7:0]    ctl_wdata = '0;
    logic          mem_wr = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic [7:0]    mem_wdata = '0;
    logic [7:0]    mem_rdata;
    logic          stat_rd = 1'b0;
    logic [7:0]    stat_rdata;
    logic          busy, loading, irq;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] mdl [MEMB];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_op_seq #(.BLK_BYTES(BLK), .NUM_BLKS(NB), .T_ERASE(TE), .T_PROG(TP)) u_dut (
        .clk(clk), .rst(rst), .unlock(unlock), .prot_mask(prot_mask),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .stat_rd(stat_rd), .stat_rdata(stat_rdata),
        .busy(busy), .loading(loading), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ctl(input logic [7:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        mem_wr = 1'b1; mem_addr = AW'(a); mem_wdata = d;
        @(negedge clk);
        mem_wr = 1'b0;
    endtask

    task automatic rd_stat(output logic [7:0] v);
        v = stat_rdata; stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic cmp_mem(input string tag);
        int bad = 0; int ba = 0; int bv = 0; int be = 0;
        for (int a = 0; a < MEMB; a++) begin
            mem_addr = AW'(a); #1;
            if (mem_rdata !== mdl[a]) begin
                if (bad == 0) begin ba = a; bv = mem_rdata; be = mdl[a]; end
                bad++;
            end
        end
        @(negedge clk);
        chk(bad == 0, $sformatf("%s memory @%0d", tag, ba), bv, be);
    endtask

    // Called right after the launching write; measures busy and checks flags.
    task automatic run_op(input int exp_dur, input string tag);
        int n = 0;
        logic [7:0] s;
        chk(busy && stat_rdata[1:0] == 2'b00, {tag, " R10 flags clear at launch"},
            {busy, stat_rdata[1:0]}, 3'b100);
        while (busy && n < 1000) begin n++; @(negedge clk); end
        chk(n == exp_dur, {tag, " R5 busy length"}, n, exp_dur);
        chk(irq == 1'b1, {tag, " R9 irq"}, irq, 1);
        rd_stat(s);
        chk(s == 8'h01, {tag, " R9 done flag"}, s, 8'h01);
        chk(stat_rdata == 8'h00, {tag, " R11 read clears"}, stat_rdata, 0);
    endtask

    task automatic byte_op(input int a, input logic [7:0] d, input bit fixed, input string tag);
        int wb = a & ~3;
        bit bl = (mdl[wb] == 0) && (mdl[wb+1] == 0) && (mdl[wb+2] == 0) && (mdl[wb+3] == 0);
        int dur = (fixed || !bl) ? TE + TP : TP;
        wr(a, d);
        run_op(dur, tag);
        mdl[a] = d;
        cmp_mem(tag);
    endtask

    task automatic finish_report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_report();
    end

    initial begin
        logic [7:0] s;
        bit seen;
        for (int a = 0; a < MEMB; a++) mdl[a] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R13 reset state
        chk(stat_rdata == 0 && !busy && !loading && !irq, "R13 reset outputs",
            {stat_rdata, busy, loading, irq}, 0);
        cmp_mem("R13 reset");

        // R1 R5 R6 R2: standard block into every block
        for (int b = 0; b < NB; b++) begin
            ctl(8'h01);
            for (int j = 0; j < BLK; j++) begin
                if (j == BLK - 1)
                    chk(loading && !busy, "R2 loading before last byte", {loading, busy}, 2'b10);
                wr(b * BLK + j, 8'((b * 40 + j * 7 + 3) & 8'hff));
            end
            run_op(TE + TP, "R5 std block");
            for (int j = 0; j < BLK; j++) mdl[b * BLK + j] = 8'((b * 40 + j * 7 + 3) & 8'hff);
            cmp_mem("R6 std block");
        end

        // R6 fast block ORs into block 1
        ctl(8'h10);
        for (int j = 0; j < BLK; j++) wr(BLK + j, 8'(8'h81 ^ (j << 4)));
        run_op(TP, "R5 fast block");
        for (int j = 0; j < BLK; j++) mdl[BLK + j] = mdl[BLK + j] | 8'(8'h81 ^ (j << 4));
        cmp_mem("R6 fast block OR");

        // Word program at address 20, then R12 trailing write acts as byte op
        ctl(8'h40);
        for (int k = 0; k < 4; k++) wr(20 + k, 8'(8'hA0 + k));
        run_op(TE + TP, "R5 word");
        for (int k = 0; k < 4; k++) mdl[20 + k] = 8'(8'hA0 + k);
        cmp_mem("R6 word");
        byte_op(21, 8'h5C, 1'b0, "R12 trailing byte");

        // R4 block erase via zero word inside block 3
        ctl(8'h20);
        for (int k = 0; k < 4; k++) wr(28 + k, 8'h00);
        run_op(TE, "R4 erase");
        for (int a = 24; a < 32; a++) mdl[a] = 8'h00;
        cmp_mem("R4 erase block");

        // R7 byte writes
        ctl(8'h00);
        byte_op(25, 8'h3C, 1'b0, "R7 byte blank word");
        byte_op(26, 8'h11, 1'b0, "R7 byte non-blank word");
        byte_op(25, 8'h00, 1'b0, "R7 byte write zero");
        ctl(8'h80);
        byte_op(29, 8'h6B, 1'b1, "R7 fixed-time byte");
        ctl(8'h00);

        // R3 partial load, then R2 out-of-sequence write ignored
        ctl(8'h01);
        for (int j = 0; j < 3; j++) wr(j, 8'(8'h50 + j));
        seen = 1'b0;
        for (int c = 0; c < 12; c++) begin
            if (busy) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen && loading, "R3 partial load holds", {seen, loading}, 2'b01);
        cmp_mem("R3 partial load");
        wr(5, 8'h99);
        chk(loading && !busy, "R2 out-of-sequence ignored", {loading, busy}, 2'b10);
        for (int j = 3; j < BLK; j++) wr(j, 8'(8'h50 + j));
        run_op(TE + TP, "R2 completed load");
        for (int j = 0; j < BLK; j++) mdl[j] = 8'(8'h50 + j);
        cmp_mem("R2 completed load");

        // R2 misaligned first word write ignored
        ctl(8'h40);
        wr(9, 8'h77);
        chk(!loading && !busy, "R2 misaligned start ignored", {loading, busy}, 0);
        cmp_mem("R2 misaligned start");

        // R8 locked write
        ctl(8'h00);
        unlock = 1'b0;
        wr(9, 8'h77);
        chk(!busy, "R8 locked no cycle", busy, 0);
        rd_stat(s);
        chk(s == 8'h02, "R8 locked flag", s, 8'h02);
        cmp_mem("R8 locked");
        unlock = 1'b1;

        // R8 protected block, flag left pending; R10 clears it at next launch
        prot_mask = 4'b0100;
        wr(18, 8'h12);
        chk(!busy && stat_rdata == 8'h02, "R8 protected flag", {busy, stat_rdata}, 8'h02);
        cmp_mem("R8 protected");
        prot_mask = '0;
        byte_op(9, 8'h77, 1'b0, "R10 launch after refusal");

        // R1 unknown code falls back to byte mode
        ctl(8'h03);
        wr(12, 8'h42);
        chk(busy, "R1 unknown code is byte mode", busy, 1);
        while (busy) @(negedge clk);
        mdl[12] = 8'h42;
        rd_stat(s);
        cmp_mem("R1 unknown code");

        finish_report();
    end
endmodule